// File: doc/BRIEF.md
# Trigger-Driven Event Frame Builder

The block assembles one output event frame for every trigger identifier that arrives in an identifier FIFO. While that FIFO is empty it does nothing. When an identifier (event number and bunch-crossing number) is available, it pops it and writes a fixed nine-word header. It then takes one sub-frame from readout source 0 and one from readout source 1, always in that order. Each source first has any leading words that are not a sub-frame header skipped. The builder then checks the sub-frame's embedded identifiers against the trigger's and compares its declared length with the count carried in its trailer. It closes the frame with a four-word footer and goes back to waiting for the next identifier.

A sub-frame whose identifiers match is copied to the output unchanged: header, payload and trailer. A sub-frame whose identifiers differ is read and dropped, and the builder records a mismatch flag for that source. The payload is never decoded. Only its length is checked. All interfaces are first-word-fall-through FIFOs. A FIFO's data is valid while its empty flag is low, and a read strobe pops it. The output FIFO is written with a strobe and holds the builder back while its full flag is high.

Top module: `evt_frame_builder`

## Requirements
- R1: While id_empty_i is high in the idle state, the builder pops nothing and writes nothing. When it is low, it pops exactly one identifier ({event[23:12], bunch[11:0]}) per frame.
- R2: A frame starts with nine header words in this order: the start word, 9, the format word, the board identifier, the event number, the bunch number, the raw identifier {event, bunch}, 0, 0. Numbers are zero-extended to 32 bits.
- R3: While looking for a sub-frame on a source, the builder pops and discards every word whose bits [31:28] are not 4'hB.
- R4: A sub-frame header is {4'hB, event[27:16], bunch[15:4], length[3:0]}. It is followed by `length` payload words and one trailer word. When event and bunch both match, all of these words are copied to the output unmodified, whatever the payload contains.
- R5: When the event or bunch number does not match, the whole sub-frame is consumed and none of it is written. Footer flags bit 0 (source 0) or bit 1 (source 1) is set.
- R6: The trailer must have bits [31:28] = 4'hE and bits [15:0] equal to the declared length. Otherwise footer flags bit 2 (source 0) or bit 3 (source 1) is set. A matching sub-frame is still appended.
- R7: Source 0's sub-frame is handled completely before source 1 is read. The two sources are never popped in the same cycle.
- R8: The footer's first word is {31'b0, any flag set}. Its second word is the flags word {28'b0, len1, len0, mis1, mis0}. Its third word is the total frame length in words, header and footer included.
- R9: The fourth footer word equals N-1, where N is the number of clock cycles from the identifier pop to the cycle of that final write. Cycles stalled on a full output or on an empty source are included.
- R10: No word is written while out_full_i is high. Stalls lose and duplicate no word.
- R11: After the last footer word, the builder returns to idle and may pop the next identifier. Consecutive frames are built back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_data_i | input | 24 | Identifier FIFO head {event, bunch} |
| id_empty_i | input | 1 | Identifier FIFO empty |
| id_rd_o | output | 1 | Identifier FIFO pop |
| src0_data_i | input | 32 | Source 0 FIFO head |
| src0_empty_i | input | 1 | Source 0 FIFO empty |
| src0_rd_o | output | 1 | Source 0 FIFO pop |
| src1_data_i | input | 32 | Source 1 FIFO head |
| src1_empty_i | input | 1 | Source 1 FIFO empty |
| src1_rd_o | output | 1 | Source 1 FIFO pop |
| out_data_o | output | 32 | Output FIFO write data |
| out_wr_o | output | 1 | Output FIFO write strobe |
| out_full_i | input | 1 | Output FIFO full |

## Verification
The hardest case to reach is a sub-frame that is both mismatched and carries a bad length on the same source, while the output is stalled in the middle of a payload whose words happen to look like sub-frame or trailer markers. The bench sweeps thirty events. Each event's lengths, matching, trailer correctness and junk prefixes come from different residues of the event number, so those combinations recur on both sources. Full and empty flags toggle on unrelated periods, so stalls fall in every phase of the frame. The build time is predicted from the observed pop cycle and final-write cycle.

// File: rtl/efb_pkg.sv
package efb_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;
  localparam int HDR_WORDS = 9;
  localparam int FTR_WORDS = 4;
  localparam logic [3:0] SUB_HDR_MARK = 4'hB;
  localparam logic [3:0] SUB_TRL_MARK = 4'hE;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_HUNT, ST_PAY, ST_TRL, ST_FTR
  } state_t;
endpackage

// File: rtl/efb_counter.sv
module efb_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (inc_i) q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/efb_sub_decode.sv
module efb_sub_decode
  import efb_pkg::*;
#(
  parameter int EVID_W = 12,
  parameter int BCID_W = 12,
  parameter int LEN_W  = 4
) (
  input  word_t             word_i,
  input  logic [EVID_W-1:0] evid_ref_i,
  input  logic [BCID_W-1:0] bcid_ref_i,
  input  logic [LEN_W-1:0]  decl_len_i,
  output logic              is_hdr_o,
  output logic              id_hit_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              trl_ok_o
);
  localparam int BCID_LSB = LEN_W;
  localparam int EVID_LSB = LEN_W + BCID_W;

  always_comb begin
    is_hdr_o = word_i[WORD_W-1 -: 4] == SUB_HDR_MARK;
    id_hit_o = (word_i[EVID_LSB +: EVID_W] == evid_ref_i) &&
               (word_i[BCID_LSB +: BCID_W] == bcid_ref_i);
    len_o    = word_i[LEN_W-1:0];
    trl_ok_o = (word_i[WORD_W-1 -: 4] == SUB_TRL_MARK) &&
               (word_i[15:0] == 16'(decl_len_i));
  end
endmodule

// File: rtl/efb_frame_word.sv
module efb_frame_word
  import efb_pkg::*;
#(
  parameter int    EVID_W   = 12,
  parameter int    BCID_W   = 12,
  parameter int    WC_W     = 16,
  parameter int    TM_W     = 20,
  parameter int    IDX_W    = 4,
  parameter word_t SOF_WORD = 32'h5EB0_F00D,
  parameter word_t FMT_WORD = 32'h0001_0002,
  parameter word_t BOARD_ID = 32'h0000_00A5
) (
  input  logic              in_ftr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [EVID_W-1:0] evid_i,
  input  logic [BCID_W-1:0] bcid_i,
  input  logic [3:0]        flags_i,
  input  logic [WC_W-1:0]   wcount_i,
  input  logic [TM_W-1:0]   timer_i,
  output word_t             word_o
);
  always_comb begin
    word_o = '0;
    if (in_ftr_i) begin
      case (idx_i)
        IDX_W'(0): word_o = word_t'(|flags_i);
        IDX_W'(1): word_o = word_t'(flags_i);
        IDX_W'(2): word_o = word_t'(wcount_i) + word_t'(2);  // this word and the next
        default:   word_o = word_t'(timer_i);
      endcase
    end else begin
      case (idx_i)
        IDX_W'(0): word_o = SOF_WORD;
        IDX_W'(1): word_o = word_t'(HDR_WORDS);
        IDX_W'(2): word_o = FMT_WORD;
        IDX_W'(3): word_o = BOARD_ID;
        IDX_W'(4): word_o = word_t'(evid_i);
        IDX_W'(5): word_o = word_t'(bcid_i);
        IDX_W'(6): word_o = word_t'({evid_i, bcid_i});
        default:   word_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/evt_frame_builder.sv
module evt_frame_builder
  import efb_pkg::*;
#(
  parameter int    EVID_W   = 12,
  parameter int    BCID_W   = 12,
  parameter int    LEN_W    = 4,
  parameter int    WC_W     = 16,
  parameter int    TM_W     = 20,
  parameter word_t SOF_WORD = 32'h5EB0_F00D,
  parameter word_t FMT_WORD = 32'h0001_0002,
  parameter word_t BOARD_ID = 32'h0000_00A5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [EVID_W+BCID_W-1:0] id_data_i,
  input  logic                     id_empty_i,
  output logic                     id_rd_o,
  input  logic [31:0]              src0_data_i,
  input  logic                     src0_empty_i,
  output logic                     src0_rd_o,
  input  logic [31:0]              src1_data_i,
  input  logic                     src1_empty_i,
  output logic                     src1_rd_o,
  output logic [31:0]              out_data_o,
  output logic                     out_wr_o,
  input  logic                     out_full_i
);
  localparam int ID_W     = EVID_W + BCID_W;
  localparam int IDX_W    = $clog2(HDR_WORDS);
  localparam int HDR_LAST = HDR_WORDS - 1;
  localparam int FTR_LAST = FTR_WORDS - 1;

  state_t             state_q;
  logic [IDX_W-1:0]   idx_q;
  logic               sel_q, keep_q;
  logic [LEN_W-1:0]   pay_cnt_q, decl_len_q;
  logic [EVID_W-1:0]  evid_q;
  logic [BCID_W-1:0]  bcid_q;
  logic [1:0]         mis_q, lerr_q;

  word_t              cur_data, gen_word;
  logic               cur_empty, go, in_src, is_hdr, id_hit, trl_ok;
  logic [LEN_W-1:0]   sub_len;
  logic [WC_W-1:0]    wcount;
  logic [TM_W-1:0]    timer;

  assign cur_data  = sel_q ? src1_data_i : src0_data_i;
  assign cur_empty = sel_q ? src1_empty_i : src0_empty_i;
  assign in_src    = (state_q == ST_HUNT) || (state_q == ST_PAY) || (state_q == ST_TRL);
  assign go        = in_src && !cur_empty && !out_full_i;

  assign id_rd_o   = (state_q == ST_IDLE) && !id_empty_i;
  assign src0_rd_o = go && !sel_q;
  assign src1_rd_o = go && sel_q;

  always_comb begin
    out_wr_o = 1'b0;
    case (state_q)
      ST_HDR, ST_FTR: out_wr_o = !out_full_i;
      ST_HUNT:        out_wr_o = go && is_hdr && id_hit;
      ST_PAY, ST_TRL: out_wr_o = go && keep_q;
      default:        out_wr_o = 1'b0;
    endcase
  end
  assign out_data_o = ((state_q == ST_HDR) || (state_q == ST_FTR)) ? gen_word : cur_data;

  efb_sub_decode #(.EVID_W(EVID_W), .BCID_W(BCID_W), .LEN_W(LEN_W)) dec_i (
    .word_i(cur_data), .evid_ref_i(evid_q), .bcid_ref_i(bcid_q), .decl_len_i(decl_len_q),
    .is_hdr_o(is_hdr), .id_hit_o(id_hit), .len_o(sub_len), .trl_ok_o(trl_ok)
  );

  efb_frame_word #(
    .EVID_W(EVID_W), .BCID_W(BCID_W), .WC_W(WC_W), .TM_W(TM_W), .IDX_W(IDX_W),
    .SOF_WORD(SOF_WORD), .FMT_WORD(FMT_WORD), .BOARD_ID(BOARD_ID)
  ) word_i (
    .in_ftr_i(state_q == ST_FTR), .idx_i(idx_q), .evid_i(evid_q), .bcid_i(bcid_q),
    .flags_i({lerr_q, mis_q}), .wcount_i(wcount), .timer_i(timer), .word_o(gen_word)
  );

  efb_counter #(.W(WC_W)) wcnt_i (
    .clk_i, .rst_ni, .clr_i(id_rd_o), .inc_i(out_wr_o), .q_o(wcount)
  );

  // build timer runs through every stall until the frame closes
  efb_counter #(.W(TM_W)) tmr_i (
    .clk_i, .rst_ni, .clr_i(id_rd_o), .inc_i(state_q != ST_IDLE), .q_o(timer)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      sel_q      <= 1'b0;
      keep_q     <= 1'b0;
      pay_cnt_q  <= '0;
      decl_len_q <= '0;
      evid_q     <= '0;
      bcid_q     <= '0;
      mis_q      <= '0;
      lerr_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (!id_empty_i) begin
          evid_q  <= id_data_i[ID_W-1 -: EVID_W];
          bcid_q  <= id_data_i[BCID_W-1:0];
          mis_q   <= '0;
          lerr_q  <= '0;
          idx_q   <= '0;
          sel_q   <= 1'b0;
          state_q <= ST_HDR;
        end
        ST_HDR: if (!out_full_i) begin
          if (idx_q == IDX_W'(HDR_LAST)) begin
            idx_q   <= '0;
            state_q <= ST_HUNT;
          end else idx_q <= idx_q + 1'b1;
        end
        ST_HUNT: if (go && is_hdr) begin
          keep_q     <= id_hit;
          decl_len_q <= sub_len;
          pay_cnt_q  <= '0;
          if (!id_hit) mis_q[sel_q] <= 1'b1;
          state_q    <= (sub_len == '0) ? ST_TRL : ST_PAY;
        end
        ST_PAY: if (go) begin
          pay_cnt_q <= pay_cnt_q + 1'b1;
          if (LEN_W'(pay_cnt_q + 1'b1) == decl_len_q) state_q <= ST_TRL;
        end
        ST_TRL: if (go) begin
          if (!trl_ok) lerr_q[sel_q] <= 1'b1;
          if (!sel_q) begin
            sel_q   <= 1'b1;
            state_q <= ST_HUNT;
          end else begin
            idx_q   <= '0;
            state_q <= ST_FTR;
          end
        end
        ST_FTR: if (!out_full_i) begin
          if (idx_q == IDX_W'(FTR_LAST)) state_q <= ST_IDLE;
          else idx_q <= idx_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/efb_checker.sv
module efb_checker #(
  parameter logic [31:0] SOF_WORD = 32'h5EB0_F00D
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        id_empty_i,
  input logic        id_rd_o,
  input logic        src0_empty_i,
  input logic        src0_rd_o,
  input logic        src1_empty_i,
  input logic        src1_rd_o,
  input logic [31:0] out_data_o,
  input logic        out_wr_o,
  input logic        out_full_i
);
  AST_ID_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_rd_o |-> !id_empty_i);  // R1
  AST_SOF_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_rd_o |=> (!out_wr_o || out_data_o == SOF_WORD));  // R2
  AST_SRC0_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src0_rd_o |-> !src0_empty_i);  // R3
  AST_SRC1_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src1_rd_o |-> !src1_empty_i);  // R3
  AST_ONE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(src0_rd_o && src1_rd_o));  // R7
  AST_NO_WR_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_full_i |-> !out_wr_o);  // R10
  AST_ID_POP_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_rd_o |=> !id_rd_o);  // R11
endmodule

bind evt_frame_builder efb_checker #(.SOF_WORD(SOF_WORD)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .id_empty_i(id_empty_i), .id_rd_o(id_rd_o),
  .src0_empty_i(src0_empty_i), .src0_rd_o(src0_rd_o),
  .src1_empty_i(src1_empty_i), .src1_rd_o(src1_rd_o),
  .out_data_o(out_data_o), .out_wr_o(out_wr_o), .out_full_i(out_full_i)
);

// File: tb/evt_frame_builder_tb_top.sv
module evt_frame_builder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NE         = 30;
  localparam int WATCHDOG   = 20000;
  localparam int ID_GATE    = 20;
  localparam logic [31:0] SOF = 32'h5EB0_F00D;
  localparam logic [31:0] FMT = 32'h0001_0002;
  localparam logic [31:0] BID = 32'h0000_00A5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [23:0] id_data;
  logic        id_empty, id_rd;
  logic [31:0] s0_data, s1_data, out_data;
  logic        s0_empty, s1_empty, s0_rd, s1_rd, out_wr, out_full;

  evt_frame_builder dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .id_data_i(id_data), .id_empty_i(id_empty), .id_rd_o(id_rd),
    .src0_data_i(s0_data), .src0_empty_i(s0_empty), .src0_rd_o(s0_rd),
    .src1_data_i(s1_data), .src1_empty_i(s1_empty), .src1_rd_o(s1_rd),
    .out_data_o(out_data), .out_wr_o(out_wr), .out_full_i(out_full)
  );

  logic [23:0] id_mem [0:63];
  logic [31:0] s0_mem [0:2047];
  logic [31:0] s1_mem [0:2047];
  logic [31:0] exp_mem [0:4095];
  bit          exp_tm  [0:4095];
  string       exp_tag [0:4095];
  int s0_n = 0, s1_n = 0, exp_n = 0;
  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_src(input int s, input logic [31:0] w);
    if (s == 0) begin s0_mem[s0_n] = w; s0_n++; end
    else        begin s1_mem[s1_n] = w; s1_n++; end
  endtask

  task automatic push_exp(input logic [31:0] w, input string tag, input bit tm);
    exp_mem[exp_n] = w; exp_tag[exp_n] = tag; exp_tm[exp_n] = tm; exp_n++;
  endtask

  task automatic build();
    for (int e = 0; e < NE; e++) begin
      logic [11:0] ev, bc;
      logic [3:0]  flags;
      int          app;
      ev = 12'((e * 37 + 5) % 4096);
      bc = 12'((e * 101 + 3) % 4096);
      id_mem[e] = {ev, bc};
      flags = '0;
      app = 0;
      push_exp(SOF, "R2", 0);            push_exp(32'd9, "R2", 0);
      push_exp(FMT, "R2", 0);            push_exp(BID, "R2", 0);
      push_exp(32'(ev), "R2", 0);        push_exp(32'(bc), "R2", 0);
      push_exp(32'({ev, bc}), "R2", 0);  push_exp(32'd0, "R2", 0);
      push_exp(32'd0, "R2", 0);
      for (int s = 0; s < 2; s++) begin
        int len; bit match, lenok;
        logic [11:0] sev;
        logic [31:0] w;
        len   = (e * 3 + s * 2) % 6;
        match = ((e + s) % 4) != 2;
        lenok = ((e + 2 * s) % 5) != 4;
        sev   = match ? ev : (ev ^ 12'h001);
        if ((e + s) % 3 == 0) begin
          push_src(s, 32'h1357_9BDF);  // R3 junk before header
          push_src(s, 32'hE000_0003);
        end
        w = {4'hB, sev, bc, 4'(len)};
        push_src(s, w);
        if (match) begin push_exp(w, s == 0 ? "R4/R7" : "R7", 0); app++; end
        for (int i = 0; i < len; i++) begin
          w = {4'((i + e) % 16), 28'(e * 64 + s * 16 + i)};  // may mimic markers
          push_src(s, w);
          if (match) begin push_exp(w, "R4", 0); app++; end
        end
        w = {4'hE, 12'h000, 16'(lenok ? len : len + 1)};
        push_src(s, w);
        if (match) begin push_exp(w, "R6", 0); app++; end
        if (!match) flags[s] = 1'b1;
        if (!lenok) flags[2 + s] = 1'b1;
      end
      push_exp({31'b0, |flags}, "R8", 0);
      push_exp(32'(flags), "R5/R6", 0);
      push_exp(32'(9 + app + 4), "R8", 0);
      push_exp(32'd0, "R9", 1);
    end
  endtask

  initial begin
    int cyc, idp, p0, p1, ep, ta, tail, full_viol, bad_pop, early, both, stalls;
    build();
    id_data = '0; id_empty = 1'b1; s0_data = '0; s1_data = '0;
    s0_empty = 1'b1; s1_empty = 1'b1; out_full = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_wr && !id_rd && !s0_rd && !s1_rd, "R1 reset", {28'b0, out_wr, id_rd, s0_rd, s1_rd}, 32'h0);
    rst_n = 1'b1;
    cyc = 0; idp = 0; p0 = 0; p1 = 0; ep = 0; ta = 0; tail = 0;
    full_viol = 0; bad_pop = 0; early = 0; both = 0; stalls = 0;
    while (tail < 30 && cyc < WATCHDOG) begin
      @(negedge clk);
      id_empty = (cyc < ID_GATE) || (idp >= NE);
      id_data  = id_mem[idp < NE ? idp : 0];
      s0_empty = (p0 >= s0_n) || (cyc % 5 == 1);
      s0_data  = s0_mem[p0 < s0_n ? p0 : 0];
      s1_empty = (p1 >= s1_n) || (cyc % 3 == 0);
      s1_data  = s1_mem[p1 < s1_n ? p1 : 0];
      out_full = (cyc % 7 == 3) || ((cyc % 50) >= 10 && (cyc % 50) < 14);
      #(CLK_PERIOD/4);
      if (out_full && out_wr) full_viol++;
      if (out_full) stalls++;
      if (cyc < ID_GATE && (out_wr || id_rd || s0_rd || s1_rd)) early++;
      if ((s0_rd && s0_empty) || (s1_rd && s1_empty) || (id_rd && id_empty)) bad_pop++;
      if (s0_rd && s1_rd) both++;
      if (id_rd) begin ta = cyc; idp++; end
      if (s0_rd) p0++;
      if (s1_rd) p1++;
      if (out_wr) begin
        if (ep >= exp_n) chk(0, "R11 extra write", out_data, 32'h0);
        else begin
          logic [31:0] ex;
          ex = exp_tm[ep] ? 32'(cyc - ta - 1) : exp_mem[ep];
          chk(out_data == ex, exp_tag[ep], out_data, ex);
          ep++;
        end
      end
      if (ep >= exp_n) tail++;
      cyc++;
    end
    if (cyc >= WATCHDOG) chk(0, "watchdog R11", 32'(ep), 32'(exp_n));
    chk(early == 0, "R1 idle while empty", 32'(early), 32'h0);
    chk(idp == NE, "R1 one pop per frame", 32'(idp), 32'(NE));
    chk(bad_pop == 0, "R3 pop on empty", 32'(bad_pop), 32'h0);
    chk(both == 0, "R7 dual pop", 32'(both), 32'h0);
    chk(full_viol == 0, "R10 write while full", 32'(full_viol), 32'h0);
    chk(stalls > 0, "R10 stalls exercised", 32'(stalls), 32'h1);
    chk(p0 == s0_n, "R5 source 0 drained", 32'(p0), 32'(s0_n));
    chk(p1 == s1_n, "R5 source 1 drained", 32'(p1), 32'(s1_n));
    chk(ep == exp_n, "R11 all frames", 32'(ep), 32'(exp_n));
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule